// File: doc/BRIEF.md
# Intra 4x4 Pixel Predictor

This block forms the predicted values for one 4x4 block of 8-bit pixels from the reconstructed samples that surround it. The caller presents eight samples from the row above the block, four samples from the column to its left, the single corner sample above and to the left, a set of availability flags and a 4-bit mode code. It then pulses `start_i` for one cycle. One clock later the block presents all sixteen predicted pixels on `pred_o` and raises `valid_o` for one cycle.

Nine prediction modes are supported. Two modes copy samples straight across. One mode fills the block with a rounded average. Six directional modes interpolate along an angle, using a rounded three-tap smoothing filter and, at some positions, a rounded two-tap average. Neighbours that are flagged missing are replaced inside the block. The DC average falls back to whichever side is present. Missing above-right samples are padded from the last above sample. Selecting the mode and adding the residual are left to the surrounding pipeline.

Top module: `intra4_pred`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `valid_o` is 0 and `pred_o` is all zeros.
- R2: `valid_o` is 1 exactly in the cycle after a cycle with `start_i` high, and 0 otherwise. `pred_o` changes only in that cycle. Inputs presented while `start_i` is low have no effect on `pred_o`.
- R3: Mode 0 (vertical) sets pixel (r,c) to above sample c. Mode 1 (horizontal) sets pixel (r,c) to left sample r.
- R4: Mode 2 (DC) with `avail_i[0]` (above present) and `avail_i[1]` (left present) both set gives every pixel (sum of the four above samples 0..3 and the four left samples + 4) >> 3.
- R5: Mode 2 with exactly one of those two flags set gives every pixel (sum of the four samples on the present side + 2) >> 2.
- R6: Mode 2 with neither flag set gives every pixel the value 128.
- R7: Modes 3 (diagonal down-left) and 7 (vertical-left) filter along the above row using f3(a,b,c) = (a+2b+c+2)>>2 and f2(a,b) = (a+b+1)>>1. Mode 3 pixel (3,3) is (a6+3·a7+2)>>2. When `avail_i[6]` is clear, above samples 4..7 are taken to equal above sample 3.
- R8: Modes 4 (diagonal down-right), 5 (vertical-right) and 6 (horizontal-down) work on the edge formed by the left samples from bottom to top, then the corner, then above samples 0..3. Mode 4 row r is the f3-filtered edge shifted by r positions. Modes 5 and 6 mix f3 and f2 at alternate positions.
- R9: Mode 8 (horizontal-up) treats left samples beyond the bottom one as copies of left sample 3. Positions with c+2r > 5 equal left sample 3.
- R10: A mode code of 9 to 15 gives every pixel the value 128, and `valid_o` still pulses.
- R11: Above sample i sits at `above_i[8i+7:8i]`. Left sample j (top to bottom) sits at `left_i[8j+7:8j]`. Pixel (r,c) sits at `pred_o[8(4r+c)+7 : 8(4r+c)]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Sample the inputs and predict one block |
| mode_i | input | 4 | Prediction mode code, 0..8 |
| avail_i | input | 8 | Bit 0 above present, bit 1 left present, bit 6 above-right present |
| above_i | input | 64 | Eight samples above, samples 0..3 over the block and 4..7 to the right |
| left_i | input | 32 | Four samples to the left, top to bottom |
| corner_i | input | 8 | Sample above and to the left |
| pred_o | output | 128 | Predicted block, row-major |
| valid_o | output | 1 | One-cycle pulse with the new block |

## Verification
The assertions assume that `start_i` is a clean synchronous level that is never unknown after reset. Apart from that, they accept any mode code, flag pattern or sample values, including codes 9 to 15. The stimulus changes all inputs only on the falling clock edge. It holds `start_i` low on idle cycles while it changes the sample buses, modes and flags at random, so the hold property sees real traffic. It also issues back-to-back starts, so the valid property sees starts in consecutive cycles and not only isolated pulses.

// File: rtl/intra4_pkg.sv
`timescale 1ns/1ps
package intra4_pkg;

    localparam int PIX_W      = 8;
    localparam int BLK_DIM    = 4;
    localparam int BLK_PIX    = BLK_DIM * BLK_DIM;
    localparam int N_ABOVE    = 2 * BLK_DIM;
    localparam int N_LEFT     = BLK_DIM;
    localparam int LINE_LEN   = 16;
    localparam int MODE_W     = 4;
    localparam int AV_W       = 8;
    localparam int AV_TOP     = 0;
    localparam int AV_LEFT    = 1;
    localparam int AV_TOPRT   = 6;

    typedef logic [PIX_W-1:0]    pix_t;
    typedef pix_t [LINE_LEN-1:0] line_t;
    typedef pix_t [BLK_PIX-1:0]  blk_t;

    localparam pix_t MID_GREY = pix_t'(1 << (PIX_W - 1));

    typedef enum logic [MODE_W-1:0] {
        M_VERT = 4'd0,
        M_HORZ = 4'd1,
        M_DC   = 4'd2,
        M_DDL  = 4'd3,
        M_DDR  = 4'd4,
        M_VR   = 4'd5,
        M_HD   = 4'd6,
        M_VL   = 4'd7,
        M_HU   = 4'd8
    } mode_e;

    // Neighbour set after substitution of missing samples.
    typedef struct packed {
        line_t top;   // above row, padded to the right
        line_t lft;   // left column, padded downward
        line_t edg;   // left bottom-to-top, corner, above 0..3
        pix_t  dc;    // flat value for the DC mode
    } nbr_t;

    function automatic pix_t tap3(pix_t a, pix_t b, pix_t c);
        logic [PIX_W+1:0] s;
        s = {2'b00, a} + {1'b0, b, 1'b0} + {2'b00, c} + (PIX_W+2)'(2);
        return s[PIX_W+1:2];
    endfunction

    function automatic pix_t tap2(pix_t a, pix_t b);
        logic [PIX_W:0] s;
        s = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
        return s[PIX_W:1];
    endfunction

endpackage

// File: rtl/intra4_nbr.sv
`timescale 1ns/1ps
module intra4_nbr
    import intra4_pkg::*;
(
    input  logic [N_ABOVE*PIX_W-1:0] above_i,
    input  logic [N_LEFT*PIX_W-1:0]  left_i,
    input  pix_t                     corner_i,
    input  logic [AV_W-1:0]          avail_i,
    output nbr_t                     nbr_o
);

    line_t top_w, lft_w, edg_w;
    pix_t  dc_w;

    // Above row: right half replaced by the last above sample when absent,
    // everything past the end repeats the last effective sample.
    for (genvar i = 0; i < LINE_LEN; i++) begin : g_top
        if (i < BLK_DIM) begin : g_own
            assign top_w[i] = above_i[i*PIX_W +: PIX_W];
        end else if (i < N_ABOVE) begin : g_rt
            assign top_w[i] = avail_i[AV_TOPRT] ? above_i[i*PIX_W +: PIX_W]
                                                : above_i[(BLK_DIM-1)*PIX_W +: PIX_W];
        end else begin : g_pad
            assign top_w[i] = top_w[N_ABOVE-1];
        end
    end

    // Left column, extended downward by its bottom sample.
    for (genvar i = 0; i < LINE_LEN; i++) begin : g_lft
        if (i < N_LEFT) begin : g_own
            assign lft_w[i] = left_i[i*PIX_W +: PIX_W];
        end else begin : g_pad
            assign lft_w[i] = left_i[(N_LEFT-1)*PIX_W +: PIX_W];
        end
    end

    // Diagonal edge: index 0..3 left bottom to top, 4 corner, 5..8 above.
    for (genvar i = 0; i < LINE_LEN; i++) begin : g_edg
        if (i < BLK_DIM) begin : g_l
            assign edg_w[i] = left_i[(BLK_DIM-1-i)*PIX_W +: PIX_W];
        end else if (i == BLK_DIM) begin : g_c
            assign edg_w[i] = corner_i;
        end else if (i <= 2*BLK_DIM) begin : g_t
            assign edg_w[i] = above_i[(i-BLK_DIM-1)*PIX_W +: PIX_W];
        end else begin : g_pad
            assign edg_w[i] = above_i[(BLK_DIM-1)*PIX_W +: PIX_W];
        end
    end

    // DC value with fallback on neighbour availability.
    logic [PIX_W+1:0] sum_t, sum_l, half_t, half_l;
    logic [PIX_W+2:0] sum_all;

    always_comb begin
        sum_t = '0;
        sum_l = '0;
        for (int i = 0; i < BLK_DIM; i++) begin
            sum_t = sum_t + (PIX_W+2)'(above_i[i*PIX_W +: PIX_W]);
            sum_l = sum_l + (PIX_W+2)'(left_i[i*PIX_W +: PIX_W]);
        end
        sum_all = (PIX_W+3)'(sum_t) + (PIX_W+3)'(sum_l) + (PIX_W+3)'(4);
        half_t  = sum_t + (PIX_W+2)'(2);
        half_l  = sum_l + (PIX_W+2)'(2);
        case ({avail_i[AV_TOP], avail_i[AV_LEFT]})
            2'b11:   dc_w = sum_all[PIX_W+2:3];
            2'b10:   dc_w = half_t[PIX_W+1:2];
            2'b01:   dc_w = half_l[PIX_W+1:2];
            default: dc_w = MID_GREY;
        endcase
    end

    assign nbr_o = '{top: top_w, lft: lft_w, edg: edg_w, dc: dc_w};

endmodule

// File: rtl/intra4_pix.sv
`timescale 1ns/1ps
module intra4_pix
    import intra4_pkg::*;
#(
    parameter int X = 0,
    parameter int Y = 0
) (
    input  logic [MODE_W-1:0] mode_i,
    input  nbr_t              nbr_i,
    output pix_t              pix_o
);

    // Per-position offsets, all resolved at elaboration.
    localparam int D    = X - Y;
    localparam int K_VR = X - (Y >> 1);
    localparam int Z_VR = 2*X - Y;
    localparam int K_HD = Y - (X >> 1);
    localparam int Z_HD = 2*Y - X;
    localparam int K_VL = X + (Y >> 1);
    localparam int K_HU = Y + (X >> 1);
    localparam int Z_HU = X + 2*Y;

    line_t t, l, e;
    assign t = nbr_i.top;
    assign l = nbr_i.lft;
    assign e = nbr_i.edg;

    always_comb begin
        case (mode_i)
            M_VERT: pix_o = t[X];
            M_HORZ: pix_o = l[Y];
            M_DC:   pix_o = nbr_i.dc;
            M_DDL:  pix_o = tap3(t[X+Y], t[X+Y+1], t[X+Y+2]);
            M_DDR:  pix_o = tap3(e[3+D], e[4+D], e[5+D]);
            M_VR: begin
                if (Z_VR >= 0 && (Z_VR % 2) == 0)
                    pix_o = tap2(e[4+K_VR], e[5+K_VR]);
                else if (Z_VR >= -1)
                    pix_o = tap3(e[3+K_VR], e[4+K_VR], e[5+K_VR]);
                else
                    pix_o = tap3(e[4-Y], e[5-Y], e[6-Y]);
            end
            M_HD: begin
                if (Z_HD >= 0 && (Z_HD % 2) == 0)
                    pix_o = tap2(e[4-K_HD], e[3-K_HD]);
                else if (Z_HD >= -1)
                    pix_o = tap3(e[5-K_HD], e[4-K_HD], e[3-K_HD]);
                else
                    pix_o = tap3(e[4+X], e[3+X], e[2+X]);
            end
            M_VL: begin
                if ((Y % 2) == 0)
                    pix_o = tap2(t[K_VL], t[K_VL+1]);
                else
                    pix_o = tap3(t[K_VL], t[K_VL+1], t[K_VL+2]);
            end
            M_HU: begin
                if (Z_HU > 5)
                    pix_o = l[N_LEFT-1];
                else if ((Z_HU % 2) == 0)
                    pix_o = tap2(l[K_HU], l[K_HU+1]);
                else
                    pix_o = tap3(l[K_HU], l[K_HU+1], l[K_HU+2]);
            end
            default: pix_o = MID_GREY;
        endcase
    end

endmodule

// File: rtl/intra4_core.sv
`timescale 1ns/1ps
module intra4_core
    import intra4_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  nbr_t              nbr_i,
    output blk_t              blk_o
);

    for (genvar gy = 0; gy < BLK_DIM; gy++) begin : g_row
        for (genvar gx = 0; gx < BLK_DIM; gx++) begin : g_col
            intra4_pix #(.X(gx), .Y(gy)) u_pix (
                .mode_i (mode_i),
                .nbr_i  (nbr_i),
                .pix_o  (blk_o[gy*BLK_DIM + gx])
            );
        end
    end

endmodule

// File: rtl/intra4_pred.sv
`timescale 1ns/1ps
module intra4_pred
    import intra4_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [MODE_W-1:0]        mode_i,
    input  logic [AV_W-1:0]          avail_i,
    input  logic [N_ABOVE*PIX_W-1:0] above_i,
    input  logic [N_LEFT*PIX_W-1:0]  left_i,
    input  logic [PIX_W-1:0]         corner_i,
    output logic [BLK_PIX*PIX_W-1:0] pred_o,
    output logic                     valid_o
);

    nbr_t nbr_w;
    blk_t blk_w, blk_q;
    logic vld_q;

    intra4_nbr u_nbr (
        .above_i  (above_i),
        .left_i   (left_i),
        .corner_i (corner_i),
        .avail_i  (avail_i),
        .nbr_o    (nbr_w)
    );

    intra4_core u_core (
        .mode_i (mode_i),
        .nbr_i  (nbr_w),
        .blk_o  (blk_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            blk_q <= '0;
        end else begin
            vld_q <= start_i;
            if (start_i)
                blk_q <= blk_w;
        end
    end

    assign pred_o  = blk_q;
    assign valid_o = vld_q;

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);

    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !valid_o);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(pred_o));

    // R10
    bad_mode_flat_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i > 4'd8) |=> (pred_o == {BLK_PIX{MID_GREY}}));

    // R6
    dc_none_flat_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i == 4'd2 && !avail_i[AV_TOP] && !avail_i[AV_LEFT])
            |=> (pred_o == {BLK_PIX{MID_GREY}}));

    // R3
    vert_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && mode_i == 4'd0)
            |=> (pred_o[BLK_DIM*PIX_W-1:0] == $past(above_i[BLK_DIM*PIX_W-1:0]))
             && (pred_o[BLK_PIX*PIX_W-1 -: BLK_DIM*PIX_W] == $past(above_i[BLK_DIM*PIX_W-1:0])));

endmodule

// File: tb/intra4_pred_bench.sv
`timescale 1ns/1ps
module intra4_pred_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [3:0]   mode;
    logic [7:0]   avail;
    logic [63:0]  above;
    logic [31:0]  left;
    logic [7:0]   corner;
    logic [127:0] pred_o;
    logic         valid_o;

    always #10 clk = ~clk;   // 50 MHz

    intra4_pred u_intra4_pred (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .mode_i   (mode),
        .avail_i  (avail),
        .above_i  (above),
        .left_i   (left),
        .corner_i (corner),
        .pred_o   (pred_o),
        .valid_o  (valid_o)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    logic         exp_v;
    logic [127:0] exp_p;
    string        exp_tag;

    // Neighbour lookup: (i,-1) above row, (-1,j) left column, (-1,-1) corner.
    function automatic int nb(int i, int j);
        if (i < 0 && j < 0) return int'(corner);
        if (j < 0) begin
            if (i > 3 && !avail[6]) i = 3;   // R7 padding
            if (i > 7) i = 7;
            return int'(above[i*8 +: 8]);
        end
        if (j > 3) j = 3;                    // R9 padding
        return int'(left[j*8 +: 8]);
    endfunction

    function automatic int f3(int a, int b, int c);
        return (a + 2*b + c + 2) >> 2;
    endfunction

    function automatic int f2(int a, int b);
        return (a + b + 1) >> 1;
    endfunction

    function automatic int ref_dc();
        int st = 0, sl = 0;
        for (int k = 0; k < 4; k++) begin
            st += nb(k, -1);
            sl += nb(-1, k);
        end
        if (avail[0] && avail[1]) return (st + sl + 4) >> 3;   // R4
        if (avail[0]) return (st + 2) >> 2;                    // R5
        if (avail[1]) return (sl + 2) >> 2;                    // R5
        return 128;                                            // R6
    endfunction

    function automatic int ref_pix(int md, int x, int y);
        int z, k;
        case (md)
            0: return nb(x, -1);
            1: return nb(-1, y);
            2: return ref_dc();
            3: begin
                if (x == 3 && y == 3) return (nb(6,-1) + 3*nb(7,-1) + 2) >> 2;
                return f3(nb(x+y,-1), nb(x+y+1,-1), nb(x+y+2,-1));
            end
            4: begin
                if (x > y) return f3(nb(x-y-2,-1), nb(x-y-1,-1), nb(x-y,-1));
                if (x < y) return f3(nb(-1,y-x-2), nb(-1,y-x-1), nb(-1,y-x));
                return f3(nb(0,-1), nb(-1,-1), nb(-1,0));
            end
            5: begin
                z = 2*x - y; k = x - (y >> 1);
                if (z >= 0 && z % 2 == 0) return f2(nb(k-1,-1), nb(k,-1));
                if (z > 0) return f3(nb(k-2,-1), nb(k-1,-1), nb(k,-1));
                if (z == -1) return f3(nb(-1,0), nb(-1,-1), nb(0,-1));
                return f3(nb(-1,y-1), nb(-1,y-2), nb(-1,y-3));
            end
            6: begin
                z = 2*y - x; k = y - (x >> 1);
                if (z >= 0 && z % 2 == 0) return f2(nb(-1,k-1), nb(-1,k));
                if (z > 0) return f3(nb(-1,k-2), nb(-1,k-1), nb(-1,k));
                if (z == -1) return f3(nb(-1,0), nb(-1,-1), nb(0,-1));
                return f3(nb(x-1,-1), nb(x-2,-1), nb(x-3,-1));
            end
            7: begin
                k = x + (y >> 1);
                if (y % 2 == 0) return f2(nb(k,-1), nb(k+1,-1));
                return f3(nb(k,-1), nb(k+1,-1), nb(k+2,-1));
            end
            8: begin
                z = x + 2*y; k = y + (x >> 1);
                if (z > 5) return nb(-1, 3);
                if (z == 5) return (nb(-1,2) + 3*nb(-1,3) + 2) >> 2;
                if (z % 2 == 0) return f2(nb(-1,k), nb(-1,k+1));
                return f3(nb(-1,k), nb(-1,k+1), nb(-1,k+2));
            end
            default: return 128;   // R10
        endcase
    endfunction

    // R11: pixel (r,c) packed at byte 4r+c.
    function automatic logic [127:0] ref_blk();
        logic [127:0] r;
        for (int y = 0; y < 4; y++)
            for (int x = 0; x < 4; x++)
                r[(y*4+x)*8 +: 8] = 8'(ref_pix(int'(mode), x, y));
        return r;
    endfunction

    function automatic string tag_of();
        case (mode)
            4'd0, 4'd1: return "R3";
            4'd2: return (avail[0] && avail[1]) ? "R4" :
                          (avail[0] || avail[1]) ? "R5" : "R6";
            4'd3, 4'd7: return "R7";
            4'd4, 4'd5, 4'd6: return "R8";
            4'd8: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (rst) begin
            exp_v   <= 1'b0;
            exp_p   <= '0;
            exp_tag <= "R1";
        end else begin
            exp_v <= start;
            if (start) begin
                exp_p   <= ref_blk();
                exp_tag <= tag_of();
            end else begin
                exp_tag <= "R2";
            end
        end
    end

    // Compare on the falling edge, then drive the next inputs.
    task automatic cycle(input logic st, input logic [3:0] md, input logic [7:0] av,
                         input logic [63:0] ab, input logic [31:0] lf, input logic [7:0] cn);
        @(negedge clk);
        n_vec++;
        if (valid_o !== exp_v) begin
            n_bad++;
            $display("FAIL R2 valid: actual=%b expected=%b", valid_o, exp_v);
        end
        if (pred_o !== exp_p) begin
            n_bad++;
            $display("FAIL %s pred: actual=%h expected=%h", exp_tag, pred_o, exp_p);
        end
        start = st; mode = md; avail = av; above = ab; left = lf; corner = cn;
    endtask

    function automatic logic [63:0] r64();
        return {$urandom, $urandom};
    endfunction

    task automatic fire(input logic [3:0] md, input logic [7:0] av,
                        input logic [63:0] ab, input logic [31:0] lf, input logic [7:0] cn);
        cycle(1'b1, md, av, ab, lf, cn);
        // R2: idle cycle with scrambled inputs must not disturb the result
        cycle(1'b0, 4'($urandom), 8'($urandom), r64(), $urandom, 8'($urandom));
    endtask

    initial begin
        logic [7:0] av_set [5] = '{8'h43, 8'h03, 8'h01, 8'h02, 8'h00};
        rst = 1'b1; start = 1'b0; mode = '0; avail = '0;
        above = '0; left = '0; corner = '0;
        // R1: reset state observed during and just after reset
        repeat (3) cycle(1'b0, 4'd0, 8'h00, '0, '0, '0);
        rst = 1'b0;
        cycle(1'b0, 4'd0, 8'h00, r64(), $urandom, 8'($urandom));

        // R3..R9: every mode under every flag pattern, random samples
        for (int m = 0; m < 9; m++)
            for (int a = 0; a < 5; a++)
                for (int n = 0; n < 3; n++)
                    fire(4'(m), av_set[a], r64(), $urandom, 8'($urandom));

        // Rounding corners: saturated and zero neighbours, alternating pattern
        for (int m = 0; m < 9; m++) begin
            fire(4'(m), 8'h43, {64{1'b1}}, {32{1'b1}}, 8'hFF);
            fire(4'(m), 8'h03, {64{1'b1}}, {32{1'b1}}, 8'hFF);
            fire(4'(m), 8'h43, '0, '0, 8'h00);
            fire(4'(m), 8'h03, 64'hFF00FF00_01FE01FE, 32'h00FF01FE, 8'h7F);
        end

        // R10: unused mode codes
        for (int m = 9; m < 16; m++)
            fire(4'(m), 8'($urandom), r64(), $urandom, 8'($urandom));

        // R2: back-to-back starts
        for (int n = 0; n < 40; n++)
            cycle(1'b1, 4'($urandom_range(0, 9)), 8'($urandom), r64(), $urandom, 8'($urandom));

        // Mixed random traffic with random start density
        for (int n = 0; n < 600; n++)
            cycle(1'($urandom_range(0, 1)), 4'($urandom), 8'($urandom),
                  r64(), $urandom, 8'($urandom));

        cycle(1'b0, 4'd0, 8'h00, '0, '0, '0);
        cycle(1'b0, 4'd0, 8'h00, '0, '0, '0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule